// File: doc/BRIEF.md
# Palette-Load DMA Request Throttle

This block sits on the DMA request line of a display controller's input FIFO. While the colour palette is being fetched, it counts the words taken out of that FIFO. Each time a group of sixteen reads completes, it suppresses the outgoing DMA request for a programmed number of clock cycles. This leaves bus slots free for other masters during the long palette fetch. A full 256-entry palette therefore produces sixteen such pauses.

Outside palette loading, for example during frame data transfer, the raw request passes straight through. A programmed pause length of zero also lets every request through. The pause length is captured when each pause starts, so software may rewrite it at any time.

Top module: `pal_dma_throttle`

## Requirements
- R1: After synchronous reset the read counter and the pause timer are both zero, and `dma_req_o` equals `dma_req_i`.
- R2: `dma_req_o` is never high while `dma_req_i` is low. The block only removes requests.
- R3: Reads (`fifo_rd_i` high on a clock edge while `pal_load_i` is high) are counted modulo 16, and need not be consecutive. The 16th counted read starts a pause.
- R4: A pause started by the read on clock edge k holds `dma_req_o` low for the `hold_cycles_i` cycles after edge k. From edge k+`hold_cycles_i` onward, `dma_req_o` follows `dma_req_i` again.
- R5: When `hold_cycles_i` is 0 at the start of a pause, no cycle is suppressed.
- R6: While `pal_load_i` is low, reads are not counted and `dma_req_o` follows `dma_req_i`.
- R7: Lowering `pal_load_i` for one edge clears the read count and any pause in progress. `dma_req_o` follows `dma_req_i` from that edge on.
- R8: `hold_cycles_i` is sampled only when a pause starts. A change during a pause does not alter that pause but applies to the next one.
- R9: A 256-word palette read one word per cycle with `hold_cycles_i` = 2 suppresses exactly 32 request cycles, in 16 pauses.
- R10: The largest setting, 255, suppresses exactly 255 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_cycles_i | input | 8 | Pause length in clock cycles, 0 disables |
| pal_load_i | input | 1 | High while the palette is being fetched |
| fifo_rd_i | input | 1 | One word taken from the input FIFO this cycle |
| dma_req_i | input | 1 | Raw DMA request |
| dma_req_o | output | 1 | Gated DMA request |

## Verification
The bench instantiates the block with its defaults: 16-word groups and an 8-bit pause setting. With these values a complete 256-word palette fits in one run, and the pauses can be counted one by one. The maximum pause of 255 cycles can also be measured in full. Scattered and interrupted read sequences show that the group count is neither lost nor double-counted, and mid-pause rewrites of the setting show where it is captured.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    localparam int unsigned PDT_GROUP_WORDS = 16;
    localparam int unsigned PDT_HOLD_W      = 8;

    // Pause timer state: remaining suppressed cycles.
    typedef struct packed {
        logic                  busy;
        logic [PDT_HOLD_W-1:0] left;
    } pdt_hold_t;

    function automatic logic pdt_is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/pdt_word_counter.sv
module pdt_word_counter #(
    parameter int unsigned GROUP_WORDS = pdt_pkg::PDT_GROUP_WORDS,
    localparam int unsigned CW = (GROUP_WORDS > 1) ? $clog2(GROUP_WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          rd,
    output logic [CW-1:0] count,
    output logic          group_done
);

    localparam logic [CW-1:0] LAST = CW'(GROUP_WORDS - 1);

    initial begin
        if (!pdt_pkg::pdt_is_pow2(GROUP_WORDS))
            $error("GROUP_WORDS must be a power of two");
    end

    assign group_done = enable && rd && (count == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count <= '0;
        end else if (rd) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pdt_holdoff_timer.sv
module pdt_holdoff_timer #(
    parameter int unsigned HOLD_W = pdt_pkg::PDT_HOLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic [HOLD_W-1:0] length,
    output logic [HOLD_W-1:0] remaining,
    output logic              holding
);

    logic [HOLD_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= length;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign remaining = left_q;
    assign holding   = (left_q != '0);

endmodule

// File: rtl/pal_dma_throttle.sv
module pal_dma_throttle #(
    parameter int unsigned GROUP_WORDS = pdt_pkg::PDT_GROUP_WORDS,
    parameter int unsigned HOLD_W      = pdt_pkg::PDT_HOLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HOLD_W-1:0] hold_cycles_i,
    input  logic              pal_load_i,
    input  logic              fifo_rd_i,
    input  logic              dma_req_i,
    output logic              dma_req_o
);

    localparam int unsigned CW = (GROUP_WORDS > 1) ? $clog2(GROUP_WORDS) : 1;

    logic [CW-1:0]     grp_cnt;
    logic              grp_done;
    logic [HOLD_W-1:0] hold_left;
    logic              hold_on;

    pdt_word_counter #(
        .GROUP_WORDS(GROUP_WORDS)
    ) u_words (
        .clk       (clk),
        .rst       (rst),
        .enable    (pal_load_i),
        .rd        (fifo_rd_i),
        .count     (grp_cnt),
        .group_done(grp_done)
    );

    pdt_holdoff_timer #(
        .HOLD_W(HOLD_W)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .enable   (pal_load_i),
        .start    (grp_done),
        .length   (hold_cycles_i),
        .remaining(hold_left),
        .holding  (hold_on)
    );

    assign dma_req_o = dma_req_i && !hold_on;

endmodule

// File: rtl/pal_dma_throttle_chk.sv
module pal_dma_throttle_chk #(
    parameter int unsigned CW     = 4,
    parameter int unsigned HOLD_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [HOLD_W-1:0] hold_cycles_i,
    input logic              pal_load_i,
    input logic              fifo_rd_i,
    input logic              dma_req_i,
    input logic              dma_req_o,
    input logic [CW-1:0]     grp_cnt,
    input logic              grp_done,
    input logic [HOLD_W-1:0] hold_left
);

    // R1: reset clears the count and the timer.
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (grp_cnt == '0) && (hold_left == '0));

    // R2
    assert_gate_only_R2: assert property (@(posedge clk) disable iff (rst)
        dma_req_o |-> dma_req_i);

    // R3
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (pal_load_i && fifo_rd_i) |=> grp_cnt == CW'($past(grp_cnt) + 1'b1));

    // R4 / R8: a pause loads the sampled length, then steps down by one.
    assert_pause_load_R8: assert property (@(posedge clk) disable iff (rst)
        grp_done |=> hold_left == $past(hold_cycles_i));

    assert_pause_step_R4: assert property (@(posedge clk) disable iff (rst)
        (pal_load_i && !grp_done && hold_left != '0) |=> hold_left == $past(hold_left) - 1'b1);

    // R5
    assert_zero_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (grp_done && hold_cycles_i == '0) |=> dma_req_o == dma_req_i);

    // R6 / R7
    assert_idle_pass_R7: assert property (@(posedge clk) disable iff (rst)
        !pal_load_i |=> (dma_req_o == dma_req_i) && (grp_cnt == '0));

endmodule

bind pal_dma_throttle pal_dma_throttle_chk #(
    .CW    (CW),
    .HOLD_W(HOLD_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .hold_cycles_i(hold_cycles_i),
    .pal_load_i   (pal_load_i),
    .fifo_rd_i    (fifo_rd_i),
    .dma_req_i    (dma_req_i),
    .dma_req_o    (dma_req_o),
    .grp_cnt      (grp_cnt),
    .grp_done     (grp_done),
    .hold_left    (hold_left)
);

// File: tb/pal_dma_throttle_tb.sv
module pal_dma_throttle_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] hold_cycles_i;
    logic       pal_load_i;
    logic       fifo_rd_i;
    logic       dma_req_i;
    logic       dma_req_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pal_dma_throttle u_dut (
        .clk          (clk),
        .rst          (rst),
        .hold_cycles_i(hold_cycles_i),
        .pal_load_i   (pal_load_i),
        .fifo_rd_i    (fifo_rd_i),
        .dma_req_i    (dma_req_i),
        .dma_req_o    (dma_req_o)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: dma_req_o=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string req);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Called at a falling edge; leaves the bench at the falling edge after the last read.
    task automatic reads(input int n);
        for (int i = 0; i < n; i++) begin
            fifo_rd_i = 1'b1;
            @(negedge clk);
        end
        fifo_rd_i = 1'b0;
    endtask

    // Counts suppressed cycles from now until the request returns.
    task automatic measure_pause(output int len);
        len = 0;
        for (int i = 0; i < 400; i++) begin
            #1;
            if (dma_req_o) break;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic clear_count();
        pal_load_i = 1'b0;
        @(negedge clk);
        pal_load_i = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; pal_load_i = 1'b1; fifo_rd_i = 1'b0; dma_req_i = 1'b1;
        hold_cycles_i = 8'd5;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1 chk(dma_req_o, 1'b1, "R1");
        @(negedge clk);
        reads(15);
        #1 chk(dma_req_o, 1'b1, "R1 count cleared by reset");
        @(negedge clk);
        clear_count();
    endtask

    task automatic t_gate();
        dma_req_i = 1'b0;
        #1 chk(dma_req_o, 1'b0, "R2 idle low");
        @(negedge clk);
        hold_cycles_i = 8'd3;
        reads(16);
        #1 chk(dma_req_o, 1'b0, "R2 low during pause");
        repeat (4) @(negedge clk);
        #1 chk(dma_req_o, 1'b0, "R2 low after pause");
        dma_req_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic_pause();
        int len;
        hold_cycles_i = 8'd5;
        reads(16);
        measure_pause(len);
        chk_int(len, 5, "R4 pause of 5");
        chk(dma_req_o, 1'b1, "R4 release");
        @(negedge clk);
    endtask

    task automatic t_scattered();
        int len;
        hold_cycles_i = 8'd4;
        for (int g = 0; g < 5; g++) begin
            reads(3);
            repeat (2) @(negedge clk);
        end
        #1 chk(dma_req_o, 1'b1, "R3 15 scattered reads");
        @(negedge clk);
        reads(1);
        measure_pause(len);
        chk_int(len, 4, "R3 16th scattered read starts pause");
        @(negedge clk);
    endtask

    task automatic t_zero();
        hold_cycles_i = 8'd0;
        reads(16);
        for (int i = 0; i < 3; i++) begin
            #1 chk(dma_req_o, 1'b1, "R5 zero setting");
            @(negedge clk);
        end
    endtask

    task automatic t_not_loading();
        int len;
        hold_cycles_i = 8'd6;
        reads(10);
        pal_load_i = 1'b0;
        reads(20);
        #1 chk(dma_req_o, 1'b1, "R6 no pause outside palette load");
        @(negedge clk);
        pal_load_i = 1'b1;
        reads(15);
        #1 chk(dma_req_o, 1'b1, "R6 reads while idle not counted");
        @(negedge clk);
        reads(1);
        measure_pause(len);
        chk_int(len, 6, "R6 group completes after reload");
        @(negedge clk);
    endtask

    task automatic t_abort();
        int len;
        hold_cycles_i = 8'd20;
        reads(16);
        #1 chk(dma_req_o, 1'b0, "R7 pause active");
        @(negedge clk);
        pal_load_i = 1'b0;
        @(negedge clk);
        pal_load_i = 1'b1;
        #1 chk(dma_req_o, 1'b1, "R7 pause cleared");
        @(negedge clk);
        reads(15);
        #1 chk(dma_req_o, 1'b1, "R7 count cleared");
        @(negedge clk);
        reads(1);
        measure_pause(len);
        chk_int(len, 20, "R7 fresh group");
        @(negedge clk);
    endtask

    task automatic t_rewrite();
        int len;
        hold_cycles_i = 8'd10;
        reads(16);
        #1;
        hold_cycles_i = 8'd3;
        measure_pause(len);
        chk_int(len, 10, "R8 running pause unchanged");
        @(negedge clk);
        reads(16);
        measure_pause(len);
        chk_int(len, 3, "R8 next pause uses new value");
        @(negedge clk);
    endtask

    task automatic t_full_palette();
        int lows = 0;
        clear_count();
        hold_cycles_i = 8'd2;
        for (int i = 0; i < 262; i++) begin
            fifo_rd_i = (i < 256);
            #1 if (!dma_req_o) lows++;
            @(negedge clk);
        end
        fifo_rd_i = 1'b0;
        chk_int(lows, 32, "R9 full palette suppressed cycles");
    endtask

    task automatic t_max();
        int len;
        clear_count();
        hold_cycles_i = 8'd255;
        reads(16);
        measure_pause(len);
        chk_int(len, 255, "R10 maximum pause");
        chk(dma_req_o, 1'b1, "R10 release");
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_gate();
        t_basic_pause();
        t_scattered();
        t_zero();
        t_not_loading();
        t_abort();
        t_rewrite();
        t_full_palette();
        t_max();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule